// File: doc/BRIEF.md
# Table Write Scheduler with Fetch-Starvation Timeout

This block sits between the request buffers of a branch-history table and the table's single port. It holds one accepted table-update request in a one-entry buffer. It writes that request into the table in any cycle where instruction fetch is not using the port. While the request waits, a counter tracks how many fetch cycles in a row have kept it out. The counter value is visible on an output.

Once the count passes a programmable threshold, the block asks the sequencer to hold off fetching for exactly one cycle. The buffered write is committed in that cycle. A new request can enter the buffer in the same cycle the old one is written, so a stream of updates flows without gaps.

The threshold is held in a small register. Reset sets it to 22, and a configuration strobe loads a new value that takes effect on the next cycle. A threshold of 0 forces a hold after the first blocking fetch.

Top module: `tws_sched`

## Requirements
- R1: The table write strobe is high only when an entry is pending and either fetch is inactive or the fetch hold is asserted. The write data equals the request payload that was accepted.
- R2: While an entry is pending, each fetch cycle that blocks its write raises the visible counter by one on the next cycle.
- R3: The counter reads 0 in any cycle after a cycle with no pending entry. It returns to 0 in the cycle after the pending write completes.
- R4: Suppose a blocking fetch takes the counter above the threshold. Then the fetch hold is high in the next cycle, for that one cycle only, and the write is performed in that cycle.
- R5: After reset the threshold is 22, so a hold appears after 23 consecutive blocking fetches. Pulsing the configuration strobe loads a new threshold, which is used from the following cycle.
- R6: With a threshold of 0, the hold follows the first blocking fetch.
- R7: The ready output is high when the buffer is empty or is being written in the current cycle. A request offered with ready high is captured, even in a write cycle.
- R8: A request offered while ready is low is ignored. The pending payload is unchanged and is the one later written.
- R9: The counter saturates at its all-ones value (31 with the default 5-bit width) instead of wrapping.
- R10: After reset the buffer is empty. Ready is 1, and the write strobe, hold and counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_active_i | input | 1 | Instruction fetch is using the table port this cycle |
| cfg_we_i | input | 1 | Load strobe for the threshold register |
| cfg_thresh_i | input | CNT_W | New threshold value |
| req_valid_i | input | 1 | A store buffer offers an update request |
| req_data_i | input | DATA_W | Update request payload |
| req_ready_o | output | 1 | The buffer can take a request this cycle |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_wdata_o | output | DATA_W | Table write payload |
| fetch_hold_o | output | 1 | Ask the sequencer to skip one fetch |
| starve_cnt_o | output | CNT_W | Consecutive blocked-fetch count |

## Verification
The hardest states to reach from the ports are the hold cycle that also accepts a fresh request, and a counter pinned at saturation. Reaching saturation needs a threshold equal to the counter maximum, so that no hold drains the entry first. The vector walk covers hand-back-to-back hold cycles, with the threshold lowered to 0 and a new request placed exactly in the hold cycle. Directed runs then use the reset threshold of 22 for 23 blocked fetches, and a maximum threshold with 40 uninterrupted fetches to pin the counter.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int TWS_DATA_W  = 8;
    localparam int TWS_CNT_W   = 5;
    localparam int TWS_THR_RST = 22;
endpackage

// File: rtl/tws_starve_ctr.sv
module tws_starve_ctr #(
    parameter int CNT_W   = tws_pkg::TWS_CNT_W,
    parameter int THR_RST = tws_pkg::TWS_THR_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_i,
    input  logic             fetch_i,
    input  logic             cfg_we_i,
    input  logic [CNT_W-1:0] cfg_thr_i,
    output logic             wr_ok_o,
    output logic             hold_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hold;
        logic [CNT_W-1:0] thr;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic             blocked;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        wr_ok_o = pend_i && (!fetch_i || st_q.hold);
        blocked = pend_i && fetch_i && !st_q.hold;
        cnt_inc = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
        st_d.hold = 1'b0;
        if (blocked) begin
            st_d.cnt  = cnt_inc;
            st_d.hold = (cnt_inc > st_q.thr);
        end else begin
            st_d.cnt  = '0;
        end
        if (cfg_we_i) begin
            st_d.thr = cfg_thr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.hold <= 1'b0;
            st_q.thr  <= CNT_W'(THR_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;
    assign cnt_o  = st_q.cnt;

    // R4
    hold_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o);
    // R4
    hold_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> pend_i);
    // R3
    idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_i |=> (cnt_o == '0));
    // R9
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX) |=> ((cnt_o == CNT_MAX) || (cnt_o == '0)));
endmodule

// File: rtl/tws_entry.sv
module tws_entry #(
    parameter int DATA_W = tws_pkg::TWS_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok_i,
    input  logic              req_valid_i,
    input  logic [DATA_W-1:0] req_data_i,
    output logic              req_ready_o,
    output logic              pend_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              pend;
        logic [DATA_W-1:0] data;
    } ent_st_t;

    ent_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d        = st_q;
        req_ready_o = !st_q.pend || wr_ok_i;
        take        = req_valid_i && req_ready_o;
        if (take) begin
            st_d.pend = 1'b1;
            st_d.data = req_data_i;
        end else if (wr_ok_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign data_o = st_q.data;

    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (pend_o && (data_o == $past(req_data_i))));
    // R8
    hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !wr_ok_i) |=> (pend_o && $stable(data_o)));
endmodule

// File: rtl/tws_sched.sv
module tws_sched #(
    parameter int DATA_W  = tws_pkg::TWS_DATA_W,
    parameter int CNT_W   = tws_pkg::TWS_CNT_W,
    parameter int THR_RST = tws_pkg::TWS_THR_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_active_i,
    input  logic              cfg_we_i,
    input  logic [CNT_W-1:0]  cfg_thresh_i,
    input  logic              req_valid_i,
    input  logic [DATA_W-1:0] req_data_i,
    output logic              req_ready_o,
    output logic              tbl_we_o,
    output logic [DATA_W-1:0] tbl_wdata_o,
    output logic              fetch_hold_o,
    output logic [CNT_W-1:0]  starve_cnt_o
);
    logic pend;
    logic wr_ok;

    tws_entry #(.DATA_W(DATA_W)) u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ok_i     (wr_ok),
        .req_valid_i (req_valid_i),
        .req_data_i  (req_data_i),
        .req_ready_o (req_ready_o),
        .pend_o      (pend),
        .data_o      (tbl_wdata_o)
    );

    tws_starve_ctr #(.CNT_W(CNT_W), .THR_RST(THR_RST)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (pend),
        .fetch_i   (fetch_active_i),
        .cfg_we_i  (cfg_we_i),
        .cfg_thr_i (cfg_thresh_i),
        .wr_ok_o   (wr_ok),
        .hold_o    (fetch_hold_o),
        .cnt_o     (starve_cnt_o)
    );

    assign tbl_we_o = wr_ok;

    // R1
    write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we_o |-> (!fetch_active_i || fetch_hold_o));
    // R4
    hold_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hold_o |-> tbl_we_o);
    // R3
    clear_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_we_o && !(req_valid_i && req_ready_o)) |=> (starve_cnt_o == '0));
endmodule

// File: tb/tws_sched_bench.sv
module tws_sched_bench;
    localparam int DW = 8;
    localparam int CW = 5;
    localparam int NV = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_thr = '0;
    logic          rv = 1'b0;
    logic [DW-1:0] rd = '0;
    logic          rdy, we, hold;
    logic [DW-1:0] wd;
    logic [CW-1:0] cnt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tws_sched u_tws_sched (
        .clk (clk), .rst_n (rst_n), .fetch_active_i (fetch),
        .cfg_we_i (cfg_we), .cfg_thresh_i (cfg_thr),
        .req_valid_i (rv), .req_data_i (rd), .req_ready_o (rdy),
        .tbl_we_o (we), .tbl_wdata_o (wd), .fetch_hold_o (hold),
        .starve_cnt_o (cnt)
    );

    // {cfg_we, thr[5], fetch, rv, rd[8], exp_we, exp_data[8], exp_hold, exp_cnt[5], exp_rdy}
    localparam logic [31:0] VEC [0:NV-1] = '{
        {1'b1, 5'd2, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b1, 8'hA1, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b0},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd1, 1'b0},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd2, 1'b0},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b1, 8'hA1, 1'b1, 5'd3, 1'b1},
        {1'b0, 5'd0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b0, 1'b1, 8'hB2, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b0, 1'b1, 8'hC3, 1'b1, 8'hB2, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b0},
        {1'b0, 5'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hC3, 1'b0, 5'd1, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b1, 5'd0, 1'b1, 1'b1, 8'hD4, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b0},
        {1'b0, 5'd0, 1'b1, 1'b1, 8'hE5, 1'b1, 8'hD4, 1'b1, 5'd1, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b0},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b1, 8'hE5, 1'b1, 5'd1, 1'b1},
        {1'b0, 5'd0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b1, 8'hF6, 1'b0, 8'h00, 1'b0, 5'd0, 1'b1},
        {1'b0, 5'd0, 1'b1, 1'b1, 8'h77, 1'b0, 8'h00, 1'b0, 5'd0, 1'b0},
        {1'b0, 5'd0, 1'b1, 1'b0, 8'h00, 1'b1, 8'hF6, 1'b1, 5'd1, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic f, input logic v, input logic [DW-1:0] d);
        @(negedge clk);
        fetch  = f;
        rv     = v;
        rd     = d;
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch = 1'b0; rv = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk("R10", "ready", 32'(rdy), 32'd1);
        chk("R10", "we", 32'(we), 32'd0);
        chk("R10", "hold", 32'(hold), 32'd0);
        chk("R10", "cnt", 32'(cnt), 32'd0);

        // Vector walk: R1 R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            @(negedge clk);
            cfg_we  = v[31];
            cfg_thr = v[30:26];
            fetch   = v[25];
            rv      = v[24];
            rd      = v[23:16];
            #1;
            chk("R1", $sformatf("vec%0d we", i), 32'(we), 32'(v[15]));
            if (v[15]) chk("R8", $sformatf("vec%0d wdata", i), 32'(wd), 32'(v[14:7]));
            chk("R4", $sformatf("vec%0d hold", i), 32'(hold), 32'(v[6]));
            chk("R2", $sformatf("vec%0d cnt", i), 32'(cnt), 32'(v[5:1]));
            chk("R7", $sformatf("vec%0d ready", i), 32'(rdy), 32'(v[0]));
        end

        // R5: reset threshold of 22 -> hold after 23 blocked fetches
        do_reset();
        drive(1'b1, 1'b1, 8'h5A);
        for (int k = 0; k <= 22; k++) begin
            drive(1'b1, 1'b0, 8'h00);
            if (cnt != CW'(k) || hold) begin
                chk("R5", $sformatf("cnt step %0d", k), 32'(cnt), 32'(k));
                chk("R5", $sformatf("no hold step %0d", k), 32'(hold), 32'd0);
            end
        end
        chk("R5", "count 22 seen", 32'(cnt), 32'd22);
        drive(1'b1, 1'b0, 8'h00);
        chk("R5", "hold after 23", 32'(hold), 32'd1);
        chk("R5", "cnt at hold", 32'(cnt), 32'd23);
        chk("R5", "write in hold", 32'(we), 32'd1);
        chk("R5", "hold payload", 32'(wd), 32'h5A);
        drive(1'b1, 1'b0, 8'h00);
        chk("R4", "hold one cycle", 32'(hold), 32'd0);
        chk("R3", "cnt cleared", 32'(cnt), 32'd0);

        // R9: saturation with the maximum threshold
        @(negedge clk);
        cfg_we = 1'b1; cfg_thr = 5'd31; fetch = 1'b0; rv = 1'b1; rd = 8'h3C;
        for (int k = 0; k < 40; k++) drive(1'b1, 1'b0, 8'h00);
        chk("R9", "cnt saturated", 32'(cnt), 32'd31);
        drive(1'b1, 1'b0, 8'h00);
        chk("R9", "cnt stays", 32'(cnt), 32'd31);
        chk("R9", "no hold at max thr", 32'(hold), 32'd0);
        drive(1'b0, 1'b0, 8'h00);
        chk("R1", "idle slot write", 32'(we), 32'd1);
        chk("R1", "idle slot data", 32'(wd), 32'h3C);
        drive(1'b0, 1'b0, 8'h00);
        chk("R3", "cnt after write", 32'(cnt), 32'd0);
        chk("R10", "empty again", 32'(rdy), 32'd1);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule